// File: doc/BRIEF.md
# Valve Drive Dither Injector

This block forms the drive word for a proportional solenoid valve. A host writes a DC setpoint. The block adds a small periodic dither term to that setpoint so the valve spool keeps moving slightly, which cuts stiction and hysteresis. The dither comes from a 32-bit phase accumulator. The waveform is either a sine, read from a quarter-wave table, or a square wave. A 16-bit amplitude word scales the waveform. The sum is clamped to the 16-bit converter code range, and the block raises a flag for every sample it clips.

The block works on sample boundaries, which are marked by a one-cycle `sampleTick` pulse. At each tick, the output register takes the setpoint, the current phase, the amplitude and the waveform choice as they stand on that clock edge. The phase then advances by the tuning word. The host can change the tuning word, the amplitude and the waveform at any time. A change applies from the next tick and keeps the running phase. When the enable input is low, the output passes the setpoint through unchanged and the phase is held at zero. The first sample after enable rises therefore starts at phase zero. A dither near 100 Hz follows from the tuning word and the sample rate.

Top module: `dither_injector`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `driveCode` is 0 and `satFlag` is 0.
- R2: `driveCode` and `satFlag` change only on the clock edge where `sampleTick` is high, one cycle after the tick is presented. Between ticks they hold their value.
- R3: On a tick with `ditherEnable` low, `driveCode` equals `setpoint` and `satFlag` is 0. On any cycle with `ditherEnable` low, the phase is forced to zero.
- R4: On a tick with enable high, the sample uses the phase held before that tick, and the phase then advances by `tuneWord` modulo 2^32. The first enabled sample uses phase 0.
- R5: With `waveSel` = 0 (sine), the waveform value is round(32767·sin(2π(p+0.5)/1024)), where p is phase bits [31:22]. Rounding is half away from zero.
- R6: With `waveSel` = 1 (square), the dither is exactly +`ditherAmp` when phase bit 31 is 0 and exactly −`ditherAmp` when it is 1.
- R7: The dither equals floor((w·A + 16384)/32768). Here w is the waveform value (±32768 for square) and A is the unsigned `ditherAmp`.
- R8: The output is `setpoint` + dither clamped to [0, 65535]. It never wraps. `satFlag` is 1 for exactly those samples that were clamped.
- R9: Changes to `tuneWord`, `ditherAmp` or `waveSel` while enabled take effect at the next tick without clearing the phase.
- R10: A `setpoint` that changes between ticks, such as a ramp, is reflected in every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle pulse marking a sample boundary |
| ditherEnable | input | 1 | Dither on (1) or pass-through with phase cleared (0) |
| waveSel | input | 1 | 0 = sine, 1 = square |
| tuneWord | input | 32 | Phase increment per sample |
| ditherAmp | input | 16 | Unsigned dither amplitude scale |
| setpoint | input | 16 | Host DC setpoint, unsigned code |
| driveCode | output | 16 | Saturated drive word for the converter |
| satFlag | output | 1 | Set when the current sample was clamped |

## Verification
A wrong phase value does not show up as a bad bit pattern. It shows as a wrong dither value on the sample that follows, one cycle after the tick. The per-clock reference comparison therefore catches a bad step, a missed clear or a stale tuning word on the first affected sample. A sign or mirror slip in the quarter-wave folding corrupts only certain quadrants. For that reason the runs sweep tuning words that visit all four quadrants many times. Clipping faults appear only near the rails, so there are dedicated runs with large amplitudes at both high and low setpoints.

// File: rtl/dither_pkg.sv
package dither_pkg;

  typedef enum logic {
    WAVE_SINE   = 1'b0,
    WAVE_SQUARE = 1'b1
  } wave_e;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic advancePhase;
    logic clearPhase;
    logic loadOutput;
    logic gateDither;
    logic pickSquare;
  } ctrl_strobe_t;

  // Quarter-wave entry, sampled at the middle of each table step
  function automatic int sineQuarterEntry(int idx, int entries, int peak);
    real ang;
    ang = 3.14159265358979323846 * (2.0 * real'(idx) + 1.0) / (4.0 * real'(entries));
    return $rtoi(real'(peak) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
(
  input  logic         sampleTick,
  input  logic         ditherEnable,
  input  logic         waveSel,
  output ctrl_strobe_t strobe
);

  always_comb begin
    strobe.loadOutput   = sampleTick;
    strobe.gateDither   = ditherEnable;
    strobe.clearPhase   = !ditherEnable;
    strobe.advancePhase = sampleTick && ditherEnable;
    strobe.pickSquare   = (wave_e'(waveSel) == WAVE_SQUARE);
  end

endmodule

// File: rtl/dither_datapath.sv
module dither_datapath
  import dither_pkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int LUT_ADDR_W = 8,
  parameter int WAVE_W     = 16,
  parameter int AMP_W      = 16,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [PHASE_W-1:0] tuneWord,
  input  logic [AMP_W-1:0]  ditherAmp,
  input  logic [DATA_W-1:0] setpoint,
  output logic [DATA_W-1:0] driveCode,
  output logic              satFlag
);

  localparam int LUT_DEPTH  = 2 ** LUT_ADDR_W;
  localparam int PEAK       = 2 ** (WAVE_W - 1) - 1;
  localparam int SQ_LEVEL   = 2 ** (WAVE_W - 1);
  localparam int WV         = WAVE_W + 1;
  localparam int SHIFT      = WAVE_W - 1;
  localparam int PROD_W     = WV + AMP_W + 1;
  localparam int DITH_W     = PROD_W - SHIFT;
  localparam int SUM_W      = DITH_W + 1;
  localparam int MAX_CODE   = 2 ** DATA_W - 1;
  localparam int ROUND_BIAS = 2 ** (SHIFT - 1);

  logic [PHASE_W-1:0]      phaseAcc;
  logic [1:0]              quadrant;
  logic [LUT_ADDR_W-1:0]   lutIdx;
  logic [LUT_ADDR_W-1:0]   lutAddr;
  logic [WAVE_W-2:0]       quarterTable [LUT_DEPTH];
  logic [WAVE_W-2:0]       quarterVal;
  logic signed [WV-1:0]    sineWave;
  logic signed [WV-1:0]    squareWave;
  logic signed [WV-1:0]    waveSig;
  logic signed [PROD_W-1:0] product;
  logic signed [DITH_W-1:0] ditherVal;
  logic signed [DITH_W-1:0] gatedDither;
  logic signed [SUM_W-1:0]  sumVal;
  logic [DATA_W-1:0]        clampVal;
  logic                     clipped;

  // Quarter-wave table built at elaboration
  for (genvar gi = 0; gi < LUT_DEPTH; gi++) begin : g_lut
    assign quarterTable[gi] = (WAVE_W-1)'(sineQuarterEntry(gi, LUT_DEPTH, PEAK));
  end

  // Phase accumulator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
    end else if (strobe.clearPhase) begin
      phaseAcc <= '0;
    end else if (strobe.advancePhase) begin
      phaseAcc <= phaseAcc + tuneWord;
    end
  end

  // Waveform shaping with quadrant folding
  assign quadrant   = phaseAcc[PHASE_W-1 -: 2];
  assign lutIdx     = phaseAcc[PHASE_W-3 -: LUT_ADDR_W];
  assign lutAddr    = quadrant[0] ? ~lutIdx : lutIdx;
  assign quarterVal = quarterTable[lutAddr];

  always_comb begin
    sineWave = $signed({2'b00, quarterVal});
    if (quadrant[1]) sineWave = -sineWave;
  end

  assign squareWave = phaseAcc[PHASE_W-1] ? -WV'(SQ_LEVEL) : WV'(SQ_LEVEL);
  assign waveSig    = strobe.pickSquare ? squareWave : sineWave;

  // Amplitude scaling with rounding
  assign product     = PROD_W'(waveSig) * PROD_W'($signed({1'b0, ditherAmp}));
  assign ditherVal   = DITH_W'((product + PROD_W'(ROUND_BIAS)) >>> SHIFT);
  assign gatedDither = strobe.gateDither ? ditherVal : '0;

  // Saturating sum
  assign sumVal = SUM_W'($signed({1'b0, setpoint})) + SUM_W'(gatedDither);

  always_comb begin
    clipped  = 1'b0;
    clampVal = sumVal[DATA_W-1:0];
    if (sumVal < 0) begin
      clampVal = '0;
      clipped  = 1'b1;
    end else if (sumVal > SUM_W'(MAX_CODE)) begin
      clampVal = DATA_W'(MAX_CODE);
      clipped  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveCode <= '0;
      satFlag   <= 1'b0;
    end else if (strobe.loadOutput) begin
      driveCode <= clampVal;
      satFlag   <= clipped;
    end
  end

  // Checks next to the logic
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(strobe.loadOutput) |-> $stable(driveCode) && $stable(satFlag));

  assert_passthrough_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(strobe.loadOutput && !strobe.gateDither)
      |-> driveCode == $past(setpoint) && !satFlag);

  assert_phase_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(strobe.clearPhase) |-> phaseAcc == '0);

  assert_phase_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(!strobe.clearPhase && !strobe.advancePhase) |-> $stable(phaseAcc));

  assert_square_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickSquare |-> (ditherVal == DITH_W'(ditherAmp)) || (ditherVal == -DITH_W'(ditherAmp)));

  assert_clip_at_rail_R8: assert property (@(posedge clk) disable iff (!rstN)
    satFlag |-> (driveCode == '0) || (driveCode == DATA_W'(MAX_CODE)));

endmodule

// File: rtl/dither_injector.sv
module dither_injector
  import dither_pkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int LUT_ADDR_W = 8,
  parameter int WAVE_W     = 16,
  parameter int AMP_W      = 16,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              ditherEnable,
  input  logic              waveSel,
  input  logic [PHASE_W-1:0] tuneWord,
  input  logic [AMP_W-1:0]  ditherAmp,
  input  logic [DATA_W-1:0] setpoint,
  output logic [DATA_W-1:0] driveCode,
  output logic              satFlag
);

  ctrl_strobe_t strobe;

  dither_ctrl i_ctrl (
    .sampleTick  (sampleTick),
    .ditherEnable(ditherEnable),
    .waveSel     (waveSel),
    .strobe      (strobe)
  );

  dither_datapath #(
    .PHASE_W   (PHASE_W),
    .LUT_ADDR_W(LUT_ADDR_W),
    .WAVE_W    (WAVE_W),
    .AMP_W     (AMP_W),
    .DATA_W    (DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tuneWord (tuneWord),
    .ditherAmp(ditherAmp),
    .setpoint (setpoint),
    .driveCode(driveCode),
    .satFlag  (satFlag)
  );

endmodule

// File: tb/test_dither_injector.sv
`timescale 1ns/1ps
module test_dither_injector;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic        ditherEnable = 1'b0;
  logic        waveSel = 1'b0;
  logic [31:0] tuneWord = '0;
  logic [15:0] ditherAmp = '0;
  logic [15:0] setpoint = '0;
  logic [15:0] driveCode;
  logic        satFlag;

  int checks = 0;
  int fails = 0;
  string curTag = "R1";
  bit done = 0;
  bit compareOn = 0;

  always #2.5 clk = ~clk;

  dither_injector i_dither_injector (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .ditherEnable(ditherEnable),
    .waveSel(waveSel), .tuneWord(tuneWord), .ditherAmp(ditherAmp),
    .setpoint(setpoint), .driveCode(driveCode), .satFlag(satFlag)
  );

  // Behavioural reference model
  longint modelPhase = 0;
  int     expCode = 0;
  bit     expSat = 0;
  int     satSeen = 0;

  function automatic longint sineValue(longint ph);
    longint p;
    real r;
    p = ph >> 22;
    r = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 1024.0);
    if (r >= 0.0) return longint'($rtoi(r + 0.5));
    return -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic longint floorDiv(longint num, longint den);
    longint q;
    q = num / den;
    if (num < 0 && q * den != num) q = q - 1;
    return q;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      modelPhase = 0;
      expCode = 0;
      expSat = 0;
    end else begin
      if (sampleTick) begin
        if (ditherEnable) begin
          longint w, d, s;
          if (waveSel) w = (modelPhase >= 64'h8000_0000) ? -32768 : 32768;
          else         w = sineValue(modelPhase);
          d = floorDiv(w * longint'(ditherAmp) + 16384, 32768);
          s = longint'(setpoint) + d;
          if (s < 0)          begin expCode = 0;     expSat = 1; end
          else if (s > 65535) begin expCode = 65535; expSat = 1; end
          else                begin expCode = int'(s); expSat = 0; end
        end else begin
          expCode = int'(setpoint);
          expSat = 0;
        end
      end
      if (!ditherEnable) modelPhase = 0;
      else if (sampleTick) modelPhase = (modelPhase + longint'(tuneWord)) & 64'hFFFF_FFFF;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", curTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn && !done) begin
      check(driveCode == 16'(expCode), "driveCode", int'(driveCode), expCode);
      check(satFlag == expSat, "satFlag", int'(satFlag), int'(expSat));
      if (satFlag) satSeen++;
    end
  end

  task automatic runTicks(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(900000.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    setpoint = 16'd1234;
    sampleTick = 1'b1;
    ditherEnable = 1'b1;
    repeat (3) @(negedge clk);
    curTag = "R1";
    check(driveCode == 0, "reset driveCode", int'(driveCode), 0);
    check(satFlag == 0, "reset satFlag", int'(satFlag), 0);
    sampleTick = 1'b0;
    ditherEnable = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(driveCode == 0, "post-reset driveCode", int'(driveCode), 0);
    compareOn = 1;

    // R3 R10: disabled, ramped setpoint passes straight through
    curTag = "R3_R10";
    ditherAmp = 16'd8000;
    tuneWord = 32'h0123_4567;
    for (int s = 0; s < 40; s++) begin
      setpoint = 16'(s * 1500);
      runTicks(1, 2);
    end
    curTag = "R3";
    check(driveCode == 16'(39 * 1500), "passthrough value", int'(driveCode), 39 * 1500);

    // R2: inputs move between ticks, output must hold
    curTag = "R2";
    setpoint = 16'd500;
    repeat (6) @(negedge clk);
    setpoint = 16'd900;
    repeat (4) @(negedge clk);

    // R4 R5 R7: sine, many quadrants, tick gaps varied
    curTag = "R4_R5_R7";
    setpoint = 16'd30000;
    ditherAmp = 16'd1000;
    waveSel = 1'b0;
    ditherEnable = 1'b1;
    tuneWord = 32'h0073_1F5B;
    runTicks(300, 1);
    runTicks(100, 0);
    tuneWord = 32'h1F00_0301;
    runTicks(200, 2);

    // R6: square wave
    curTag = "R6";
    waveSel = 1'b1;
    ditherAmp = 16'd5000;
    tuneWord = 32'h0400_0000;
    runTicks(150, 1);

    // R9: on-the-fly changes keep phase
    curTag = "R9";
    for (int s = 0; s < 30; s++) begin
      tuneWord = 32'h0100_0000 + 32'(s) * 32'h0031_0005;
      ditherAmp = 16'(3000 + s * 700);
      waveSel = s[2];
      runTicks(4, 1);
    end

    // R8: clipping at both rails
    curTag = "R8";
    waveSel = 1'b0;
    ditherAmp = 16'd20000;
    tuneWord = 32'h0200_0000;
    setpoint = 16'd65000;
    runTicks(130, 1);
    setpoint = 16'd100;
    runTicks(130, 1);
    ditherAmp = 16'hFFFF;
    setpoint = 16'd32768;
    runTicks(130, 1);
    waveSel = 1'b1;
    setpoint = 16'd0;
    runTicks(40, 1);
    check(satSeen > 0, "clip observed", satSeen, 1);

    // R3 R4: drop and re-enable restarts phase
    curTag = "R3_R4";
    waveSel = 1'b0;
    ditherAmp = 16'd30000;
    setpoint = 16'd20000;
    tuneWord = 32'h0377_0011;
    runTicks(17, 1);
    ditherEnable = 1'b0;
    repeat (3) @(negedge clk);
    runTicks(3, 1);
    ditherEnable = 1'b1;
    runTicks(1, 1);
    // Phase 0 sine value 101, scaled: floor((101*30000+16384)/32768) = 92
    check(driveCode == 16'd20092, "first sample at phase zero", int'(driveCode), 20092);
    runTicks(50, 0);

    // R10: ramp up and down while dithering
    curTag = "R10";
    for (int s = 0; s < 64; s++) begin
      setpoint = 16'(s < 32 ? s * 2000 : (63 - s) * 2000);
      runTicks(2, 1);
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule